// File: doc/BRIEF.md
# 64-bit Bit-Manipulation Execution Unit

This unit computes the bit-manipulation results of a 64-bit integer pipeline: single-bit set/clear/invert/extract, shifts that fill with ones, half-word and byte packing, scaled address additions, counts and rotates on the low 32-bit word, and a full byte reverse. Each operation takes two 64-bit operands and a shift amount. The shift amount comes either from a 7-bit immediate or from the low bits of operand two. The unit returns a 64-bit result and an illegal flag.

Operations enter on a valid/ready stream and leave on another one. With the default output register, an operation is accepted on any clock where `in_valid` and `in_ready` are both high. Its result appears on the output one cycle later. The input is ready whenever the output register is empty or is being drained in the same cycle, so back-pressure from `out_ready` reaches `in_ready` combinationally and throughput stays at one per clock. While `out_valid` is high and `out_ready` is low, the output holds its value unchanged. With `OUT_REG` set to 0, the stage is a wire: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `bmu_alu`

## Requirements
- R1: Operation codes on `in_op` are: 0 set-bit, 1 clear-bit, 2 invert-bit, 3 extract-bit, 4 shift-ones-left, 5 shift-ones-right, 6 pack, 7 pack-upper, 8 pack-high, 9 pack-word, 10 pack-upper-word, 11/12/13 shift-by-1/2/3-and-add, 14/15/16 the same on the zero-extended low word, 17 add-unsigned-word, 18 trailing-zero-count-word, 19 leading-zero-count-word, 20 popcount-word, 21 rotate-left-word, 22 rotate-right-word, 23 byte-reverse. Set, clear and invert OR, AND-NOT or XOR operand one with a mask that is a single one shifted left by the amount.
- R2: Extract returns bit [amount] of operand one in bit 0, with all other bits zero.
- R3: Shift-ones-left and shift-ones-right shift operand one by the amount and fill the vacated positions with ones.
- R4: Pack gives {b[31:0], a[31:0]}; pack-upper gives {b[63:32], a[63:32]}; pack-high gives {48 zeros, b[7:0], a[7:0]}.
- R5: Pack-word gives a[15:0] in bits 15:0 and b[15:0] sign-extended into bits 63:16; pack-upper-word sign-extends the 32-bit value {b[31:16], a[31:16]} to 64 bits.
- R6: Shift-and-add gives (a << n) + b for n = 1, 2, 3; the word forms shift the zero-extended a[31:0]; add-unsigned-word gives the zero-extended a[31:0] plus b; all additions wrap modulo 2^64.
- R7: Trailing-zero-count-word and leading-zero-count-word count over a[31:0] only and give 32 when a[31:0] is zero; popcount-word counts the ones of a[31:0] only.
- R8: Rotate-left-word and rotate-right-word rotate a[31:0] by the amount and sign-extend the 32-bit result to 64 bits.
- R9: With `in_imm_sel` low, the amount is b[5:0] for full-width operations (0 to 5, 23) and b[4:0] for word rotates; with `in_imm_sel` high, it is `in_imm` (its low 5 bits for word rotates).
- R10: Byte-reverse swaps all eight bytes of operand one when the selected amount equals 56; any other amount raises the illegal flag.
- R11: An immediate of 64 or more on an amount-using operation (codes 0 to 5, 21 to 23), or any code from 24 to 31, raises `out_illegal` and drives `out_result` to zero.
- R12: After reset `out_valid` is low. An accepted operation is presented one cycle later, and a presented result stays unchanged until `out_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the input |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 5 | Operation code (see R1) |
| in_a | input | 64 | Operand one |
| in_b | input | 64 | Operand two, also the register-sourced amount |
| in_imm | input | 7 | Immediate shift amount |
| in_imm_sel | input | 1 | 1 selects the immediate as the amount |
| out_valid | output | 1 | Result present on the output |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Operation result |
| out_illegal | output | 1 | Operation was illegal; result is zero |

## Verification
The properties assume that `in_op` and `in_a` carry known values whenever `in_valid` is high. They place no demand on `out_ready`: they only constrain what the unit does while the consumer stalls. The stimulus always drives defined operands and holds each operation steady until it is accepted. It toggles `out_ready` pseudo-randomly, so hold cycles, back-to-back transfers and idle gaps all occur. Immediates are aimed at the 56 and 64 boundaries and at undefined codes, so the illegal path is also covered.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int BMU_OPW = 5;

  typedef enum logic [BMU_OPW-1:0] {
    BMU_BSET    = 5'd0,
    BMU_BCLR    = 5'd1,
    BMU_BINV    = 5'd2,
    BMU_BEXT    = 5'd3,
    BMU_ONESL   = 5'd4,
    BMU_ONESR   = 5'd5,
    BMU_PACK    = 5'd6,
    BMU_PACKU   = 5'd7,
    BMU_PACKH   = 5'd8,
    BMU_PACKW   = 5'd9,
    BMU_PACKUW  = 5'd10,
    BMU_SCL1    = 5'd11,
    BMU_SCL2    = 5'd12,
    BMU_SCL3    = 5'd13,
    BMU_SCL1W   = 5'd14,
    BMU_SCL2W   = 5'd15,
    BMU_SCL3W   = 5'd16,
    BMU_ADDZW   = 5'd17,
    BMU_TZCW    = 5'd18,
    BMU_LZCW    = 5'd19,
    BMU_POPW    = 5'd20,
    BMU_ROTLW   = 5'd21,
    BMU_ROTRW   = 5'd22,
    BMU_REV     = 5'd23
  } bmu_op_e;

endpackage

// File: rtl/bmu_amount.sv
module bmu_amount
  import bmu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 7,
  localparam int SHW = $clog2(XLEN)
) (
  input  bmu_op_e          op,
  input  logic [IMMW-1:0]  imm,
  input  logic             imm_sel,
  input  logic [SHW-1:0]   b_lo,
  output logic [SHW-1:0]   amt_full,
  output logic [SHW-2:0]   amt_word,
  output logic             imm_bad
);

  logic uses_amt;
  logic [SHW-1:0] amt_sel;

  always_comb begin
    case (op)
      BMU_BSET, BMU_BCLR, BMU_BINV, BMU_BEXT,
      BMU_ONESL, BMU_ONESR, BMU_ROTLW, BMU_ROTRW, BMU_REV: uses_amt = 1'b1;
      default:                                            uses_amt = 1'b0;
    endcase
  end

  assign amt_sel  = imm_sel ? imm[SHW-1:0] : b_lo;
  assign amt_full = amt_sel;
  assign amt_word = amt_sel[SHW-2:0];

  generate
    if (IMMW > SHW) begin : g_range
      localparam logic [IMMW-1:0] IMM_LIM = IMMW'(XLEN);
      assign imm_bad = imm_sel && uses_amt && (imm >= IMM_LIM);
    end else begin : g_norange
      assign imm_bad = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bmu_wcount.sv
module bmu_wcount #(
  parameter int HW = 32,
  localparam int CW = $clog2(HW) + 1
) (
  input  logic [HW-1:0] w,
  output logic [CW-1:0] tz,
  output logic [CW-1:0] lz,
  output logic [CW-1:0] pop
);

  always_comb begin
    tz = CW'(HW);
    for (int i = HW - 1; i >= 0; i--) begin
      if (w[i]) tz = CW'(i);
    end
  end

  always_comb begin
    lz = CW'(HW);
    for (int i = 0; i < HW; i++) begin
      if (w[i]) lz = CW'(HW - 1 - i);
    end
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < HW; i++) begin
      pop = pop + CW'(w[i]);
    end
  end

endmodule

// File: rtl/bmu_core.sv
module bmu_core
  import bmu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2,
  localparam int QTR  = HALF / 2,
  localparam int SHW  = $clog2(XLEN),
  localparam int CW   = $clog2(HALF) + 1,
  localparam int NBY  = XLEN / 8
) (
  input  bmu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [SHW-1:0]   amt_full,
  input  logic [SHW-2:0]   amt_word,
  input  logic [CW-1:0]    tz,
  input  logic [CW-1:0]    lz,
  input  logic [CW-1:0]    pop,
  input  logic             imm_bad,
  output logic [XLEN-1:0]  result,
  output logic             illegal
);

  localparam logic [SHW-1:0] REV_AMT = SHW'(XLEN - 8);

  logic [XLEN-1:0]   bit_mask;
  logic [XLEN-1:0]   a_zw;
  logic [HALF-1:0]   a_lo;
  logic [2*HALF-1:0] rot_l_wide;
  logic [2*HALF-1:0] rot_r_wide;
  logic [HALF-1:0]   rot_l;
  logic [HALF-1:0]   rot_r;
  logic [HALF-1:0]   pk_uw;
  logic [XLEN-1:0]   swapped;
  logic [XLEN-1:0]   raw;
  logic              bad_op;
  logic              rev_bad;

  assign a_lo     = a[HALF-1:0];
  assign a_zw     = {{HALF{1'b0}}, a_lo};
  assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << amt_full;

  assign rot_l_wide = {a_lo, a_lo} << amt_word;
  assign rot_r_wide = {a_lo, a_lo} >> amt_word;
  assign rot_l      = rot_l_wide[2*HALF-1:HALF];
  assign rot_r      = rot_r_wide[HALF-1:0];

  assign pk_uw = {b[HALF-1:QTR], a[HALF-1:QTR]};

  generate
    for (genvar g = 0; g < NBY; g++) begin : g_swap
      assign swapped[g*8 +: 8] = a[(NBY-1-g)*8 +: 8];
    end
  endgenerate

  always_comb begin
    bad_op = 1'b0;
    raw    = '0;
    case (op)
      BMU_BSET:   raw = a | bit_mask;
      BMU_BCLR:   raw = a & ~bit_mask;
      BMU_BINV:   raw = a ^ bit_mask;
      BMU_BEXT:   raw = {{(XLEN-1){1'b0}}, a[amt_full]};
      BMU_ONESL:  raw = ~((~a) << amt_full);
      BMU_ONESR:  raw = ~((~a) >> amt_full);
      BMU_PACK:   raw = {b[HALF-1:0], a[HALF-1:0]};
      BMU_PACKU:  raw = {b[XLEN-1:HALF], a[XLEN-1:HALF]};
      BMU_PACKH:  raw = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};
      BMU_PACKW:  raw = {{HALF{b[QTR-1]}}, b[QTR-1:0], a[QTR-1:0]};
      BMU_PACKUW: raw = {{HALF{pk_uw[HALF-1]}}, pk_uw};
      BMU_SCL1:   raw = (a << 1) + b;
      BMU_SCL2:   raw = (a << 2) + b;
      BMU_SCL3:   raw = (a << 3) + b;
      BMU_SCL1W:  raw = (a_zw << 1) + b;
      BMU_SCL2W:  raw = (a_zw << 2) + b;
      BMU_SCL3W:  raw = (a_zw << 3) + b;
      BMU_ADDZW:  raw = a_zw + b;
      BMU_TZCW:   raw = {{(XLEN-CW){1'b0}}, tz};
      BMU_LZCW:   raw = {{(XLEN-CW){1'b0}}, lz};
      BMU_POPW:   raw = {{(XLEN-CW){1'b0}}, pop};
      BMU_ROTLW:  raw = {{HALF{rot_l[HALF-1]}}, rot_l};
      BMU_ROTRW:  raw = {{HALF{rot_r[HALF-1]}}, rot_r};
      BMU_REV:    raw = swapped;
      default:    bad_op = 1'b1;
    endcase
  end

  assign rev_bad = (op == BMU_REV) && (amt_full != REV_AMT);
  assign illegal = bad_op | imm_bad | rev_bad;
  assign result  = illegal ? '0 : raw;

endmodule

// File: rtl/bmu_alu.sv
module bmu_alu
  import bmu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IMMW    = 7,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BMU_OPW-1:0] in_op,
  input  logic [XLEN-1:0]    in_a,
  input  logic [XLEN-1:0]    in_b,
  input  logic [IMMW-1:0]    in_imm,
  input  logic               in_imm_sel,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [XLEN-1:0]    out_result,
  output logic               out_illegal
);

  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);
  localparam int CW   = $clog2(HALF) + 1;

  bmu_op_e         op;
  logic [SHW-1:0]  amt_full;
  logic [SHW-2:0]  amt_word;
  logic            imm_bad;
  logic [CW-1:0]   tz_cnt;
  logic [CW-1:0]   lz_cnt;
  logic [CW-1:0]   pop_cnt;
  logic [XLEN-1:0] core_result;
  logic            core_illegal;

  assign op = bmu_op_e'(in_op);

  bmu_amount #(.XLEN(XLEN), .IMMW(IMMW)) u_amount (
    .op       (op),
    .imm      (in_imm),
    .imm_sel  (in_imm_sel),
    .b_lo     (in_b[SHW-1:0]),
    .amt_full (amt_full),
    .amt_word (amt_word),
    .imm_bad  (imm_bad)
  );

  bmu_wcount #(.HW(HALF)) u_wcount (
    .w   (in_a[HALF-1:0]),
    .tz  (tz_cnt),
    .lz  (lz_cnt),
    .pop (pop_cnt)
  );

  bmu_core #(.XLEN(XLEN)) u_core (
    .op       (op),
    .a        (in_a),
    .b        (in_b),
    .amt_full (amt_full),
    .amt_word (amt_word),
    .tz       (tz_cnt),
    .lz       (lz_cnt),
    .pop      (pop_cnt),
    .imm_bad  (imm_bad),
    .result   (core_result),
    .illegal  (core_illegal)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic            vld_q;
      logic [XLEN-1:0] res_q;
      logic            ill_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          ill_q <= 1'b0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) begin
            res_q <= core_result;
            ill_q <= core_illegal;
          end
        end
      end

      assign in_ready    = !vld_q || out_ready;
      assign out_valid   = vld_q;
      assign out_result  = res_q;
      assign out_illegal = ill_q;
    end else begin : g_wire
      assign in_ready    = out_ready;
      assign out_valid   = in_valid;
      assign out_result  = core_result;
      assign out_illegal = core_illegal;
    end
  endgenerate

endmodule

// File: rtl/bmu_alu_chk.sv
module bmu_alu_chk
  import bmu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1,
  localparam int HALF   = XLEN / 2,
  localparam int CW     = $clog2(HALF) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [BMU_OPW-1:0] in_op,
  input logic [HALF-1:0]    in_a_lo,
  input logic               out_valid,
  input logic               out_ready,
  input logic [XLEN-1:0]    out_result,
  input logic               out_illegal,
  input logic [CW-1:0]      tz_cnt,
  input logic               core_illegal
);

  // R12: a stalled result does not move
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_illegal)));

  // R12: an accepted operation is presented next cycle
  p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && in_valid && in_ready) |=> out_valid);

  // R11: illegal results are zero
  p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  // R11: undefined codes are flagged
  p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op > BMU_OPW'(BMU_REV))) |-> core_illegal);

  // R7: trailing count reaches the word width only for a zero word
  p_tz_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((in_a_lo == '0) == (tz_cnt == CW'(HALF))));

  // R7: trailing count never exceeds the word width
  p_tz_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (tz_cnt <= CW'(HALF)));

endmodule

bind bmu_alu bmu_alu_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_op        (in_op),
  .in_a_lo      (in_a[XLEN/2-1:0]),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_illegal  (out_illegal),
  .tz_cnt       (tz_cnt),
  .core_illegal (core_illegal)
);

// File: tb/bmu_alu_test.sv
module bmu_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [6:0]  in_imm = '0;
  logic        in_imm_sel = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_illegal;

  always #5 clk = ~clk;

  bmu_alu uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_a, .in_b,
    .in_imm, .in_imm_sel, .out_valid, .out_ready, .out_result, .out_illegal
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  bit    accepted;
  bit    stall_mode = 0;
  logic [63:0] q_res[$];
  bit          q_ill[$];
  string       q_tag[$];
  bit          hold_pend = 0;
  logic [63:0] hold_res;
  bit          hold_ill;

  function automatic void model(input logic [4:0] op, input logic [63:0] a,
                                input logic [63:0] b, input logic [6:0] imm,
                                input logic sel, output logic [63:0] r,
                                output bit ill, output string tag);
    logic [6:0]  amt;
    logic [31:0] w, t;
    int s6, s5, cnt;
    bit uses;
    amt = sel ? imm : {1'b0, b[5:0]};
    s6 = int'(amt[5:0]);
    s5 = int'(amt[4:0]);
    w = a[31:0];
    r = '0;
    ill = 0;
    uses = (op <= 5) || (op >= 21 && op <= 23);
    case (op)
      0: begin r = a | (64'd1 << s6); tag = "R1"; end
      1: begin r = a & ~(64'd1 << s6); tag = "R1"; end
      2: begin r = a ^ (64'd1 << s6); tag = "R1"; end
      3: begin r = {63'd0, a[s6]}; tag = "R2"; end
      4: begin r = ~((~a) << s6); tag = "R3"; end
      5: begin r = ~((~a) >> s6); tag = "R3"; end
      6: begin r = {b[31:0], a[31:0]}; tag = "R4"; end
      7: begin r = {b[63:32], a[63:32]}; tag = "R4"; end
      8: begin r = {48'd0, b[7:0], a[7:0]}; tag = "R4"; end
      9: begin r = {{32{b[15]}}, b[15:0], a[15:0]}; tag = "R5"; end
      10: begin t = {b[31:16], a[31:16]}; r = {{32{t[31]}}, t}; tag = "R5"; end
      11, 12, 13: begin r = (a << (op - 10)) + b; tag = "R6"; end
      14, 15, 16: begin r = ({32'd0, w} << (op - 13)) + b; tag = "R6"; end
      17: begin r = {32'd0, w} + b; tag = "R6"; end
      18: begin cnt = 0; while (cnt < 32 && !w[cnt]) cnt++; r = 64'(cnt); tag = "R7"; end
      19: begin cnt = 0; while (cnt < 32 && !w[31-cnt]) cnt++; r = 64'(cnt); tag = "R7"; end
      20: begin cnt = 0; for (int i = 0; i < 32; i++) if (w[i]) cnt++; r = 64'(cnt); tag = "R7"; end
      21: begin t = (w << s5) | (w >> (32 - s5)); r = {{32{t[31]}}, t}; tag = "R8"; end
      22: begin t = (w >> s5) | (w << (32 - s5)); r = {{32{t[31]}}, t}; tag = "R8"; end
      23: begin
        tag = "R10";
        if (amt == 7'd56) begin
          for (int i = 0; i < 8; i++) r[i*8 +: 8] = a[(7-i)*8 +: 8];
        end else ill = 1;
      end
      default: begin ill = 1; tag = "R11"; end
    endcase
    if (uses && !sel) tag = {tag, "/R9"};
    if (uses && sel && imm >= 7'd64) begin ill = 1; tag = {tag, "/R11"}; end
    if (ill) r = '0;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // evaluated after inputs settle, before the next rising edge
  task automatic monitor();
    logic [63:0] r;
    bit ill;
    string tag;
    accepted = 0;
    if (hold_pend) begin
      check("R12 hold", out_valid && out_result === hold_res && out_illegal === hold_ill,
            out_result, hold_res);
      hold_pend = 0;
    end
    if (out_valid && out_ready) begin
      if (q_res.size() == 0) begin
        check("R12 spurious", 1'b0, out_result, '0);
      end else begin
        r = q_res.pop_front();
        ill = q_ill.pop_front();
        tag = q_tag.pop_front();
        check(tag, out_result === r && out_illegal === ill,
              {out_result[62:0], out_illegal}, {r[62:0], ill});
      end
    end else if (out_valid) begin
      hold_pend = 1;
      hold_res  = out_result;
      hold_ill  = out_illegal;
    end
    if (in_valid && in_ready) begin
      model(in_op, in_a, in_b, in_imm, in_imm_sel, r, ill, tag);
      q_res.push_back(r);
      q_ill.push_back(ill);
      q_tag.push_back(tag);
      accepted = 1;
    end
  endtask

  task automatic cycle();
    out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    #1;
    monitor();
    @(negedge clk);
  endtask

  task automatic send(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                      input logic [6:0] imm, input logic sel);
    in_op = op; in_a = a; in_b = b; in_imm = imm; in_imm_sel = sel;
    in_valid = 1'b1;
    do cycle(); while (!accepted);
    in_valid = 1'b0;
  endtask

  localparam logic [63:0] PA = 64'h8123_4567_89AB_CDEF;
  localparam logic [63:0] PB = 64'hF0E1_D2C3_B4A5_9687;

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset out_valid", out_valid === 1'b0, {63'd0, out_valid}, 64'd0);
    check("R12 reset in_ready", in_ready === 1'b1, {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1..R3 single-bit and ones-shift
    send(0, 64'd0, 64'd0, 7'd63, 1);
    send(1, '1, 64'd0, 7'd0, 1);
    send(2, PA, 64'd5, 7'd0, 0);
    send(3, PA, 64'd63, 7'd0, 0);
    send(4, 64'd0, 64'd0, 7'd8, 1);
    send(5, 64'd0, 64'd0, 7'd60, 1);
    // R9: upper bits of the register amount ignored
    send(0, 64'd0, 64'hFFFF_FFFF_FFFF_FFC3, 7'd0, 0);
    send(21, 64'h0000_0000_8000_0001, 64'd33, 7'd0, 0);
    send(22, 64'h0000_0000_0000_0001, 64'd0, 7'd97, 0);
    send(21, 64'hFFFF_FFFF_4000_0000, 64'd0, 7'd33, 1);
    // R4..R6 packing and scaled adds
    for (int op = 6; op <= 17; op++) send(5'(op), PA, PB, 7'd0, 0);
    send(9, PA, 64'h0000_0000_0000_7FFF, 7'd0, 0);
    send(13, '1, 64'd7, 7'd0, 0);
    // R7 counts, zero word and upper-half isolation
    send(18, 64'hFFFF_FFFF_0000_0000, 0, 0, 0);
    send(19, 64'hFFFF_FFFF_0000_0000, 0, 0, 0);
    send(20, 64'hFFFF_FFFF_0000_00F0, 0, 0, 0);
    send(18, 64'h0000_0000_8000_0000, 0, 0, 0);
    send(19, 64'h0000_0000_0000_0001, 0, 0, 0);
    // R10 byte reverse boundaries
    send(23, PA, 0, 7'd56, 1);
    send(23, PA, 64'd56, 7'd0, 0);
    send(23, PA, 0, 7'd48, 1);
    send(23, PA, 0, 7'd120, 1);
    // R11 range and undefined codes
    send(0, PA, 0, 7'd64, 1);
    send(5, PA, 0, 7'd127, 1);
    send(22, PA, 0, 7'd64, 1);
    send(6, PA, PB, 7'd100, 1);
    send(24, PA, PB, 0, 0);
    send(31, PA, PB, 0, 0);
    // random traffic under back-pressure (R12)
    stall_mode = 1;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 4) == 0) cycle();
      send(5'($urandom_range(0, 31)),
           {$urandom, ($urandom_range(0, 5) == 0) ? 32'd0 : $urandom},
           {$urandom, $urandom},
           ($urandom_range(0, 3) == 0) ? 7'd56 : 7'($urandom_range(0, 80)),
           1'($urandom_range(0, 1)));
    end
    stall_mode = 0;
    for (int n = 0; n < 8; n++) cycle();
    check("R12 drain", q_res.size() == 0, 64'(q_res.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule